// File: doc/BRIEF.md
# TFT Panel Strobe Timing Generator

This block produces the control strobes that a portrait 240x320 TFT panel needs next to its 16-bit parallel pixel stream. One pixel clock drives five free-running pulse channels. The channels are a one-clock line pulse, a one-clock per-line start pulse, a long frame-start pulse, an active-low sample/clear strobe, and a polarity reversal square wave. Each channel is a wrapping counter with a fixed period and active width. Both are derived at elaboration time from the pixel clock rate, the frame rate and the visible and blanking line counts.

A level enable starts the channels in a fixed, staggered order. A small sequencer state machine has four states. SEQ_IDLE has all channels stopped. SEQ_REV runs only the reversal channel. SEQ_REV_LINE adds the line pulse. SEQ_ALL adds the start, frame and sample/clear channels. The sequencer takes four transitions:
- SEQ_IDLE to SEQ_REV when enable is high.
- SEQ_REV to SEQ_REV_LINE when the reversal counter exceeds REV_THR.
- SEQ_REV_LINE to SEQ_ALL when the line counter reaches LINE_THR.
- Any running state to SEQ_IDLE when enable is low.

Dropping the enable stops every channel together and parks each output at its inactive level. The next enable replays the whole staggered start.

Top module: `tft_strobe_gen`

## Requirements
- R1: The line length in clocks is CPL = PIX_CLK_HZ / FRAME_HZ / (VIS_LINES + BLANK_LINES), using integer division with any remainder dropped. With the default parameters this gives 303. The line pulse repeats every CPL clocks.
- R2: `line_pulse` is active high and exactly one clock wide, once per line.
- R3: `start_pulse` is active high and one clock wide, with a period of CPL clocks.
- R4: `frame_pulse` is active high for 2*CPL clocks and repeats every CPL*(VIS_LINES+BLANK_LINES) clocks.
- R5: `sclr_n` is active low for ACT_PIX+PRE_PIX clocks at the start of each line and high for the rest of the line. Its period is CPL clocks.
- R6: `rev` is high for CPL clocks and low for the next CPL clocks, starting high.
- R7: Start-up order is fixed. Let k count cycles, with k=0 as the first cycle in which `rev` is high after enable:
  - `rev` goes high in the cycle after `en` is sampled high.
  - `line_pulse` is first high at k = REV_THR+2. This is the cycle after the reversal counter, which reads 0 at k=0, has been seen above REV_THR.
  - `start_pulse`, `frame_pulse` and `sclr_n` begin together at k = REV_THR+2+LINE_THR+1.
- R8: During and right after reset every output is inactive: `sclr_n` high, all others low.
- R9: When `en` is low at a clock edge, all outputs are inactive from the next cycle and stay so while `en` stays low. A later enable repeats the R7 sequence from k=0.
- R10: Once all channels run, the falling edge of `sclr_n`, the rising edge of `frame_pulse` and every `start_pulse` share the same line phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Level enable for the strobe channels |
| line_pulse | output | 1 | One-clock line pulse, active high |
| start_pulse | output | 1 | One-clock per-line start pulse, active high |
| frame_pulse | output | 1 | Two-line frame start pulse, active high |
| sclr_n | output | 1 | Sample/clear strobe, active low |
| rev | output | 1 | Polarity reversal, one line high and one line low |

## Verification
The bench builds the block with PIX_CLK_HZ=125, FRAME_HZ=1, VIS_LINES=4, BLANK_LINES=2, ACT_PIX=6 and PRE_PIX=2. These values give a 20-clock line with a remainder of 5 that must be dropped. A frame then lasts only 120 clocks, so several complete frames, frame-pulse wraps and reversal periods fit into each enabled run. The default thresholds of 11 and 3 are kept, and both stay below the short line length. This keeps the staggered start fully visible, with the line pulse at k=13 and the remaining channels at k=17. Random enable lengths cut the sequence in every state, including during the start-up stagger.

// File: rtl/tft_strobe_pkg.sv
`timescale 1ns/1ps
package tft_strobe_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE     = 2'd0,
        SEQ_REV      = 2'd1,
        SEQ_REV_LINE = 2'd2,
        SEQ_ALL      = 2'd3
    } seq_state_e;

    localparam int unsigned NUM_CH   = 5;
    localparam int unsigned CH_REV   = 0;
    localparam int unsigned CH_LINE  = 1;
    localparam int unsigned CH_START = 2;
    localparam int unsigned CH_FRAME = 3;
    localparam int unsigned CH_SCLR  = 4;

    function automatic int unsigned ch_period(input int unsigned ch,
                                              input int unsigned cpl,
                                              input int unsigned nl);
        case (ch)
            CH_REV:   return 2 * cpl;
            CH_FRAME: return cpl * nl;
            default:  return cpl;
        endcase
    endfunction

    function automatic int unsigned ch_width(input int unsigned ch,
                                             input int unsigned cpl,
                                             input int unsigned sw);
        case (ch)
            CH_REV:   return cpl;
            CH_FRAME: return 2 * cpl;
            CH_SCLR:  return sw;
            default:  return 1;
        endcase
    endfunction

    function automatic bit ch_act_low(input int unsigned ch);
        return (ch == CH_SCLR);
    endfunction

endpackage

// File: rtl/strobe_chan.sv
`timescale 1ns/1ps
module strobe_chan #(
    parameter int unsigned CW      = 17,
    parameter int unsigned PERIOD  = 303,
    parameter int unsigned WIDTH   = 1,
    parameter bit          ACT_LOW = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [CW-1:0] cnt,
    output logic          strobe
);
    localparam logic [CW-1:0] LAST  = CW'(PERIOD - 1);
    localparam logic [CW-1:0] WID_C = CW'(WIDTH);

    logic active;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        active = run && (cnt < WID_C);
        strobe = ACT_LOW ? ~active : active;
    end

    // Counter never leaves its period window (R1)
    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // A stopped channel restarts from phase zero (R9)
    assert_stop_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);

endmodule

// File: rtl/start_seq.sv
`timescale 1ns/1ps
module start_seq
    import tft_strobe_pkg::*;
#(
    parameter int unsigned CW       = 17,
    parameter int unsigned REV_THR  = 11,
    parameter int unsigned LINE_THR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CW-1:0]     rev_cnt,
    input  logic [CW-1:0]     line_cnt,
    output logic [NUM_CH-1:0] run
);
    localparam logic [CW-1:0] REV_T  = CW'(REV_THR);
    localparam logic [CW-1:0] LINE_T = CW'(LINE_THR);

    seq_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SEQ_IDLE:     if (en) state_nxt = SEQ_REV;
            SEQ_REV: begin
                if (!en)                  state_nxt = SEQ_IDLE;
                else if (rev_cnt > REV_T) state_nxt = SEQ_REV_LINE;
            end
            SEQ_REV_LINE: begin
                if (!en)                    state_nxt = SEQ_IDLE;
                else if (line_cnt >= LINE_T) state_nxt = SEQ_ALL;
            end
            SEQ_ALL:      if (!en) state_nxt = SEQ_IDLE;
            default:      state_nxt = SEQ_IDLE;
        endcase
    end

    always_comb begin
        run = '0;
        unique case (state)
            SEQ_IDLE:     run = '0;
            SEQ_REV:      run[CH_REV] = 1'b1;
            SEQ_REV_LINE: begin
                run[CH_REV]  = 1'b1;
                run[CH_LINE] = 1'b1;
            end
            SEQ_ALL:      run = '1;
            default:      run = '0;
        endcase
    end

    // Line channel starts only after reversal counter exceeded threshold (R7)
    assert_line_after_rev_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run[CH_LINE]) |-> ($past(rev_cnt) > REV_T));

    // Late channels start only after line counter reached threshold (R7)
    assert_late_after_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run[CH_START]) |-> ($past(line_cnt) >= LINE_T));

    // Start order is never inverted (R7)
    assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run[CH_START] |-> (run[CH_LINE] && run[CH_REV]));

    // Enable low always returns to idle (R9)
    assert_drop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state == SEQ_IDLE);

endmodule

// File: rtl/tft_strobe_gen.sv
`timescale 1ns/1ps
module tft_strobe_gen
    import tft_strobe_pkg::*;
#(
    parameter int unsigned PIX_CLK_HZ  = 6_000_000,
    parameter int unsigned FRAME_HZ    = 60,
    parameter int unsigned VIS_LINES   = 320,
    parameter int unsigned BLANK_LINES = 9,
    parameter int unsigned ACT_PIX     = 240,
    parameter int unsigned PRE_PIX     = 8,
    parameter int unsigned REV_THR     = 11,
    parameter int unsigned LINE_THR    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic line_pulse,
    output logic start_pulse,
    output logic frame_pulse,
    output logic sclr_n,
    output logic rev
);
    localparam int unsigned NL         = VIS_LINES + BLANK_LINES;
    localparam int unsigned CPL        = PIX_CLK_HZ / FRAME_HZ / NL;
    localparam int unsigned SW         = ACT_PIX + PRE_PIX;
    localparam int unsigned FRAME_CLKS = CPL * NL;
    localparam int unsigned CW         = $clog2(FRAME_CLKS + 1);
    localparam logic [CW-1:0] CPL_C    = CW'(CPL);

    logic [CW-1:0]     cnt [NUM_CH];
    logic [NUM_CH-1:0] strobe;
    logic [NUM_CH-1:0] run;

    start_seq #(
        .CW       (CW),
        .REV_THR  (REV_THR),
        .LINE_THR (LINE_THR)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .rev_cnt  (cnt[CH_REV]),
        .line_cnt (cnt[CH_LINE]),
        .run      (run)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        strobe_chan #(
            .CW      (CW),
            .PERIOD  (ch_period(g, CPL, NL)),
            .WIDTH   (ch_width(g, CPL, SW)),
            .ACT_LOW (ch_act_low(g))
        ) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run[g]),
            .cnt    (cnt[g]),
            .strobe (strobe[g])
        );
    end

    assign rev         = strobe[CH_REV];
    assign line_pulse  = strobe[CH_LINE];
    assign start_pulse = strobe[CH_START];
    assign frame_pulse = strobe[CH_FRAME];
    assign sclr_n      = strobe[CH_SCLR];

    // Line pulse lasts one clock (R2)
    assert_line_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_pulse |=> !line_pulse);

    // Start pulse lasts one clock (R3)
    assert_start_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    // Disabled channels park inactive (R9)
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!line_pulse && !start_pulse && !frame_pulse && sclr_n && !rev));

    // Late channels share line phase (R10)
    assert_aligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
        run[CH_START] |-> ((cnt[CH_START] == cnt[CH_SCLR]) &&
                           ((cnt[CH_FRAME] % CPL_C) == cnt[CH_START])));

    // Frame pulse rises only on a start pulse (R10)
    assert_frame_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_pulse) |-> start_pulse);

endmodule

// File: tb/test_tft_strobe_gen.sv
`timescale 1ns/1ps
module test_tft_strobe_gen;
    localparam int unsigned P_PIX   = 125;
    localparam int unsigned P_FR    = 1;
    localparam int unsigned P_VIS   = 4;
    localparam int unsigned P_BLK   = 2;
    localparam int unsigned P_ACT   = 6;
    localparam int unsigned P_PRE   = 2;
    localparam int unsigned P_RTHR  = 11;
    localparam int unsigned P_LTHR  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic line_pulse, start_pulse, frame_pulse, sclr_n, rev;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    tft_strobe_gen #(
        .PIX_CLK_HZ (P_PIX), .FRAME_HZ (P_FR), .VIS_LINES (P_VIS),
        .BLANK_LINES(P_BLK), .ACT_PIX (P_ACT), .PRE_PIX (P_PRE),
        .REV_THR (P_RTHR), .LINE_THR (P_LTHR)
    ) i_tft_strobe_gen (
        .clk(clk), .rst_n(rst_n), .en(en),
        .line_pulse(line_pulse), .start_pulse(start_pulse),
        .frame_pulse(frame_pulse), .sclr_n(sclr_n), .rev(rev)
    );

    function automatic int exp_nl();  return P_VIS + P_BLK; endfunction
    function automatic int exp_cpl(); return P_PIX / P_FR / exp_nl(); endfunction
    function automatic int exp_l0();  return P_RTHR + 2; endfunction
    function automatic int exp_a0();  return exp_l0() + P_LTHR + 1; endfunction

    function automatic bit m_rev(input int k);
        return (k % (2 * exp_cpl())) < exp_cpl();
    endfunction
    function automatic bit m_line(input int k);
        if (k < exp_l0()) return 1'b0;
        return ((k - exp_l0()) % exp_cpl()) == 0;
    endfunction
    function automatic bit m_start(input int k);
        if (k < exp_a0()) return 1'b0;
        return ((k - exp_a0()) % exp_cpl()) == 0;
    endfunction
    function automatic bit m_frame(input int k);
        if (k < exp_a0()) return 1'b0;
        return ((k - exp_a0()) % (exp_cpl() * exp_nl())) < 2 * exp_cpl();
    endfunction
    function automatic bit m_sclr_n(input int k);
        if (k < exp_a0()) return 1'b1;
        return !(((k - exp_a0()) % exp_cpl()) < (P_ACT + P_PRE));
    endfunction

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t",
                     req, what, act, exp, $time);
        end
    endtask

    task automatic check_quiet(input string req);
        check(req, "line_pulse idle", int'(line_pulse), 0);
        check(req, "start_pulse idle", int'(start_pulse), 0);
        check(req, "frame_pulse idle", int'(frame_pulse), 0);
        check(req, "sclr_n idle", int'(sclr_n), 1);
        check(req, "rev idle", int'(rev), 0);
    endtask

    // Enable and compare every output against the model for n cycles
    task automatic run_on(input int n);
        int last_rise = -1;
        en = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check("R6", "rev", int'(rev), int'(m_rev(k)));
            check("R2", "line_pulse", int'(line_pulse), int'(m_line(k)));
            check("R3", "start_pulse", int'(start_pulse), int'(m_start(k)));
            check("R4", "frame_pulse", int'(frame_pulse), int'(m_frame(k)));
            check("R5", "sclr_n", int'(sclr_n), int'(m_sclr_n(k)));
            if (k == exp_l0())
                check("R7", "line first high", int'(line_pulse), 1);
            if (k == exp_a0())
                check("R7_R10", "late channels together",
                      int'(start_pulse && frame_pulse && !sclr_n), 1);
            if (line_pulse) begin
                if (last_rise >= 0)
                    check("R1", "line period", k - last_rise, exp_cpl());
                last_rise = k;
            end
        end
    endtask

    task automatic run_off(input int n);
        en = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check_quiet("R9");
        end
    endtask

    initial begin
        en = 1'b1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_quiet("R8");
        check("R1", "truncated line length", exp_cpl(), 20);
        rst_n = 1'b1;
        // Directed: three full frames straight out of reset with enable high
        run_on(exp_a0() + 3 * exp_cpl() * exp_nl());
        run_off(4);
        // Directed: drop during the stagger, before line pulse begins
        run_on(exp_l0() - 1);
        run_off(2);
        // Directed: drop between line pulse start and late channels
        run_on(exp_a0() - 1);
        run_off(1);
        // Random lengths with a fixed seed
        void'($urandom(32'd1234));
        for (int i = 0; i < 12; i++) begin
            run_on(1 + int'($urandom % 400));
            run_off(1 + int'($urandom % 6));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
            $finish;
        end
    end

endmodule